// File: doc/BRIEF.md
# Power Management Event Interrupt Controller

This block collects power-management events and turns them into a single level-sensitive system control interrupt line (`sci`). It keeps a 16-bit fixed-event status word, a 16-bit fixed-event enable word, and a small bank of general-purpose event bytes. The lower half of that bank holds status bytes and the upper half holds enable bytes. Hardware pulses set the status bits: timer carry, power-button request, wake indications with a cause code, and a general-purpose event pattern. Status bits stay set until software clears them. Software writes a one to a bit to clear it, and writes the enable masks directly.

Software reaches the registers over a simple single-cycle bus. `reg_wide` = 1 marks a 16-bit little-endian access and `reg_wide` = 0 marks a byte access. The fixed status word is at byte offset 0 and the fixed enable word at offset 2, and both take word accesses only. The general-purpose bank starts at `GPE_BASE` (default 0x20) and takes byte accesses only. Read data is combinational from `reg_addr`.

There is no sequencing in this block. Every register updates on the same clock edge that presents the access, and `sci` follows the registers combinationally.

Top module: `pm_event_ctrl`

## Requirements
- R1: After reset, the fixed status word, the fixed enable word and every general-purpose status and enable byte read as zero, and `sci` is low.
- R2: A word write to offset 0 clears each fixed status bit written as one. Bits written as zero keep their value.
- R3: A word write to offset 2 replaces the whole fixed enable word with the written value.
- R4: A `pwrbtn_req` pulse sets status bit 8 only if enable bit 8 is already set. Otherwise the pulse leaves status unchanged.
- R5: A `wake_valid` pulse always sets wake status bit 15. It also sets a second bit chosen by `wake_cause`: 1 (RTC) sets bit 10, 2 (timer) sets bit 0, and 3 (other) sets bit 8 whatever the enable word holds. Cause 0 sets bit 15 only.
- R6: A `tmr_carry` pulse sets status bit 0.
- R7: `sci` is high exactly when (fixed status AND fixed enable AND 0x0721) is nonzero, or when (general-purpose status byte 0 AND enable byte 0) is nonzero. A status bit whose enable is clear, or a bit outside the mask such as bit 15, does not raise `sci`.
- R8: Bank byte index `i` below `GPE_BYTES/2` is a status byte and is cleared by writing ones. Index `GPE_BYTES/2 + k` is enable byte `k` and is written directly.
- R9: A `gpe_evt_valid` pulse ORs `gpe_evt_bits` into general-purpose status byte 0.
- R10: A byte access to a fixed register, or a word access to the general-purpose bank, changes nothing and reads zero.
- R11: Reads from unmapped offsets return zero, and writes to them change no register.
- R12: If a hardware set and a software clear hit the same status bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 16 | Write data, little-endian; byte accesses use bits 7:0 |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| tmr_carry | input | 1 | Timer carry pulse |
| pwrbtn_req | input | 1 | Power-button request pulse |
| wake_valid | input | 1 | Wake indication pulse |
| wake_cause | input | 2 | Wake cause: 0 none, 1 RTC, 2 timer, 3 other |
| gpe_evt_valid | input | 1 | General-purpose event pulse |
| gpe_evt_bits | input | 8 | Pattern ORed into general-purpose status byte 0 |
| sci | output | 1 | Level-sensitive system control interrupt |

## Verification
Some rules are checked by assertions on every clock cycle: write-one-to-clear of the fixed status word, replacement of the enable word, the set-over-clear priority, the power-button enable gate, and the latching of general-purpose event patterns. Other behaviour appears only in the bench scenarios. These are the wake-cause-to-bit mapping, the interrupt equation with its common mask and its general-purpose term, the rejection of wrong-width and unmapped accesses, and the split of the bank into status and enable halves.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
    localparam int REG_W    = 16;
    localparam int BIT_TMR  = 0;
    localparam int BIT_PWR  = 8;
    localparam int BIT_RTC  = 10;
    localparam int BIT_WAKE = 15;
    localparam logic [REG_W-1:0] COMMON_MASK = 16'h0721;

    typedef enum logic [1:0] {
        WAKE_NONE  = 2'd0,
        WAKE_RTC   = 2'd1,
        WAKE_TMR   = 2'd2,
        WAKE_OTHER = 2'd3
    } wake_cause_e;

    function automatic logic [REG_W-1:0] wake_set_bits(input wake_cause_e c);
        logic [REG_W-1:0] v;
        v = '0;
        v[BIT_WAKE] = 1'b1;
        unique case (c)
            WAKE_RTC:   v[BIT_RTC] = 1'b1;
            WAKE_TMR:   v[BIT_TMR] = 1'b1;
            WAKE_OTHER: v[BIT_PWR] = 1'b1;
            WAKE_NONE:  v = v;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/pm_fixed_evt.sv
module pm_fixed_evt
    import pm_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sts_wr,
    input  logic             en_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] set_vec,
    output logic [REG_W-1:0] sts,
    output logic [REG_W-1:0] en
);
    logic [REG_W-1:0] clr_vec;

    always_comb clr_vec = sts_wr ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts <= '0;
            en  <= '0;
        end else begin
            sts <= (sts & ~clr_vec) | set_vec;
            if (en_wr) en <= wdata;
        end
    end

    // R2
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && set_vec == '0) |=> sts == ($past(sts) & ~$past(wdata)));

    // R3
    en_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> en == $past(wdata));

    // R12
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> (sts & $past(set_vec)) == $past(set_vec));
endmodule

// File: rtl/pm_gpe_bank.sv
module pm_gpe_bank #(
    parameter int GPE_BYTES = 4,
    localparam int HALF  = GPE_BYTES / 2,
    localparam int IDX_W = (GPE_BYTES > 1) ? $clog2(GPE_BYTES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      idx,
    input  logic [7:0]            wdata,
    input  logic                  evt_valid,
    input  logic [7:0]            evt_bits,
    output logic [HALF-1:0][7:0]  sts,
    output logic [HALF-1:0][7:0]  en,
    output logic [7:0]            rd_byte
);
    for (genvar g = 0; g < HALF; g++) begin : g_byte
        logic       sts_hit, en_hit;
        logic [7:0] set_b;
        assign sts_hit = wr_en && (idx == IDX_W'(g));
        assign en_hit  = wr_en && (idx == IDX_W'(HALF + g));
        if (g == 0) begin : g_evt
            assign set_b = evt_valid ? evt_bits : 8'h00;
        end else begin : g_noevt
            assign set_b = 8'h00;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sts[g] <= 8'h00;
                en[g]  <= 8'h00;
            end else begin
                sts[g] <= (sts[g] & ~(sts_hit ? wdata : 8'h00)) | set_b;
                if (en_hit) en[g] <= wdata;
            end
        end
    end

    always_comb begin
        rd_byte = 8'h00;
        for (int i = 0; i < HALF; i++) begin
            if (idx == IDX_W'(i))        rd_byte = sts[i];
            if (idx == IDX_W'(HALF + i)) rd_byte = en[i];
        end
    end

    // R9
    gpe_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> (sts[0] & $past(evt_bits)) == $past(evt_bits));
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
    import pm_evt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int GPE_BYTES = 4,
    parameter int GPE_BASE  = 32,
    localparam int HALF  = GPE_BYTES / 2,
    localparam int IDX_W = (GPE_BYTES > 1) ? $clog2(GPE_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_wide,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              tmr_carry,
    input  logic              pwrbtn_req,
    input  logic              wake_valid,
    input  logic [1:0]        wake_cause,
    input  logic              gpe_evt_valid,
    input  logic [7:0]        gpe_evt_bits,
    output logic              sci
);
    logic [REG_W-1:0]     fx_sts, fx_en, fx_set;
    logic                 sel_sts, sel_en, sel_gpe;
    logic [ADDR_W-1:0]    gpe_off;
    logic [HALF-1:0][7:0] g_sts, g_en;
    logic [7:0]           g_rd;

    always_comb begin
        gpe_off = reg_addr - ADDR_W'(GPE_BASE);
        sel_sts = reg_wide && (reg_addr == ADDR_W'(0));
        sel_en  = reg_wide && (reg_addr == ADDR_W'(2));
        sel_gpe = !reg_wide && (reg_addr >= ADDR_W'(GPE_BASE))
                  && (gpe_off < ADDR_W'(GPE_BYTES));
    end

    always_comb begin
        fx_set = '0;
        if (tmr_carry) fx_set[BIT_TMR] = 1'b1;
        if (pwrbtn_req && fx_en[BIT_PWR]) fx_set[BIT_PWR] = 1'b1;
        if (wake_valid) fx_set = fx_set | wake_set_bits(wake_cause_e'(wake_cause));
    end

    pm_fixed_evt u_fixed (
        .clk     (clk),
        .rst_n   (rst_n),
        .sts_wr  (reg_wr && sel_sts),
        .en_wr   (reg_wr && sel_en),
        .wdata   (reg_wdata),
        .set_vec (fx_set),
        .sts     (fx_sts),
        .en      (fx_en)
    );

    pm_gpe_bank #(.GPE_BYTES(GPE_BYTES)) u_gpe (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr && sel_gpe),
        .idx       (gpe_off[IDX_W-1:0]),
        .wdata     (reg_wdata[7:0]),
        .evt_valid (gpe_evt_valid),
        .evt_bits  (gpe_evt_bits),
        .sts       (g_sts),
        .en        (g_en),
        .rd_byte   (g_rd)
    );

    always_comb begin
        reg_rdata = 16'h0000;
        if (sel_sts)      reg_rdata = fx_sts;
        else if (sel_en)  reg_rdata = fx_en;
        else if (sel_gpe) reg_rdata = {8'h00, g_rd};
    end

    always_comb sci = (|(fx_sts & fx_en & COMMON_MASK)) || (|(g_sts[0] & g_en[0]));

    // R4
    pwr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(pwrbtn_req && fx_en[BIT_PWR]) && !(wake_valid && wake_cause == 2'd3))
        |=> !$rose(fx_sts[BIT_PWR]));
endmodule

// File: tb/pm_event_ctrl_tb.sv
module pm_event_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_wide = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        tmr_carry = 1'b0, pwrbtn_req = 1'b0, wake_valid = 1'b0;
    logic [1:0]  wake_cause = '0;
    logic        gpe_evt_valid = 1'b0;
    logic [7:0]  gpe_evt_bits = '0;
    logic        sci;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    int unsigned exp_q[$];
    bit          kind_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_event_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wide(reg_wide),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tmr_carry(tmr_carry), .pwrbtn_req(pwrbtn_req), .wake_valid(wake_valid),
        .wake_cause(wake_cause), .gpe_evt_valid(gpe_evt_valid),
        .gpe_evt_bits(gpe_evt_bits), .sci(sci)
    );

    // monitor: pops expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                automatic int unsigned e = exp_q.pop_front();
                automatic bit k = kind_q.pop_front();
                automatic string t = tag_q.pop_front();
                automatic int unsigned act = k ? 32'(sci) : 32'(reg_rdata);
                checks++;
                if (act != e) begin
                    errors++;
                    $display("FAIL %s: %s actual=0x%0h expected=0x%0h",
                             t, k ? "sci" : "rdata", act, e);
                end
            end
        end
    end

    task automatic idle_cycle();
        @(posedge clk); #1;
        reg_wr = 0; tmr_carry = 0; pwrbtn_req = 0; wake_valid = 0; gpe_evt_valid = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic w, input logic [15:0] d);
        idle_cycle();
        reg_wr = 1; reg_wide = w; reg_addr = a; reg_wdata = d;
    endtask

    task automatic rd(input logic [7:0] a, input logic w, input int unsigned e, input string t);
        idle_cycle();
        reg_wide = w; reg_addr = a;
        exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(t);
    endtask

    task automatic chk_sci(input bit e, input string t);
        idle_cycle();
        exp_q.push_back(32'(e)); kind_q.push_back(1'b1); tag_q.push_back(t);
    endtask

    task automatic wake(input logic [1:0] c);
        idle_cycle();
        wake_valid = 1; wake_cause = c;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(8'h00, 1, 0, "R1 sts"); rd(8'h02, 1, 0, "R1 en");
        rd(8'h20, 0, 0, "R1 gsts0"); rd(8'h22, 0, 0, "R1 gen0");
        chk_sci(0, "R1 sci");
        // R3 enable replace
        wr(8'h02, 1, 16'h0501); rd(8'h02, 1, 16'h0501, "R3 en");
        wr(8'h02, 1, 16'h0100); rd(8'h02, 1, 16'h0100, "R3 en replace");
        // R4 power button gated on
        idle_cycle(); pwrbtn_req = 1;
        rd(8'h00, 1, 16'h0100, "R4 pwr set"); chk_sci(1, "R7 pwr sci");
        // R2 clear
        wr(8'h00, 1, 16'h0100); rd(8'h00, 1, 0, "R2 clear"); chk_sci(0, "R7 sci low");
        // R4 gated off
        wr(8'h02, 1, 16'h0000);
        idle_cycle(); pwrbtn_req = 1;
        rd(8'h00, 1, 0, "R4 pwr ignored");
        // R5 rtc wake
        wake(2'd1); rd(8'h00, 1, 16'h8400, "R5 rtc wake"); chk_sci(0, "R7 no enable");
        wr(8'h02, 1, 16'h8000); chk_sci(0, "R7 wake bit masked");
        wr(8'h02, 1, 16'h0400); chk_sci(1, "R7 rtc enabled");
        // R2 zeros keep
        wr(8'h00, 1, 16'h8000); rd(8'h00, 1, 16'h0400, "R2 zeros keep");
        wr(8'h00, 1, 16'h0400); rd(8'h00, 1, 0, "R2 clear rtc");
        // R5 timer + other
        wake(2'd2); rd(8'h00, 1, 16'h8001, "R5 tmr wake");
        wake(2'd3); rd(8'h00, 1, 16'h8101, "R5 other wake");
        wr(8'h00, 1, 16'hFFFF); rd(8'h00, 1, 0, "R2 clear all");
        wake(2'd0); rd(8'h00, 1, 16'h8000, "R5 none cause");
        wr(8'h00, 1, 16'hFFFF);
        // R6 timer carry
        idle_cycle(); tmr_carry = 1;
        rd(8'h00, 1, 16'h0001, "R6 carry");
        wr(8'h02, 1, 16'h0001); chk_sci(1, "R7 tmr sci");
        // R12 set wins
        wr(8'h00, 1, 16'h0001); tmr_carry = 1;
        rd(8'h00, 1, 16'h0001, "R12 set wins");
        wr(8'h00, 1, 16'h0001); rd(8'h00, 1, 0, "R2 after set wins");
        chk_sci(0, "R7 cleared");
        // R8 / R9 general-purpose bank
        wr(8'h22, 0, 16'h0005); rd(8'h22, 0, 16'h0005, "R8 gen0");
        idle_cycle(); gpe_evt_valid = 1; gpe_evt_bits = 8'h04;
        rd(8'h20, 0, 16'h0004, "R9 gsts0"); chk_sci(1, "R9 gpe sci");
        wr(8'h20, 0, 16'h0000); rd(8'h20, 0, 16'h0004, "R8 w0 keeps");
        wr(8'h20, 0, 16'h0004); rd(8'h20, 0, 0, "R8 w1c"); chk_sci(0, "R8 sci low");
        idle_cycle(); gpe_evt_valid = 1; gpe_evt_bits = 8'h02;
        rd(8'h20, 0, 16'h0002, "R9 unmasked latch"); chk_sci(0, "R7 gpe masked");
        wr(8'h23, 0, 16'h00AA); rd(8'h23, 0, 16'h00AA, "R8 gen1");
        rd(8'h21, 0, 0, "R8 gsts1");
        // R10 width mismatch
        wr(8'h02, 0, 16'hFFFF); rd(8'h02, 1, 16'h0001, "R10 byte to fixed");
        wr(8'h22, 1, 16'h00FF); rd(8'h22, 0, 16'h0005, "R10 word to gpe");
        rd(8'h02, 0, 0, "R10 byte read fixed");
        rd(8'h22, 1, 0, "R10 word read gpe");
        // R11 unmapped
        wr(8'h10, 1, 16'hFFFF); rd(8'h10, 1, 0, "R11 unmapped read");
        rd(8'h02, 1, 16'h0001, "R11 en intact"); rd(8'h04, 1, 0, "R11 offset4");
        rd(8'h24, 0, 0, "R11 past bank");
        idle_cycle(); idle_cycle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule